// File: doc/BRIEF.md
# Dual-Start Burst Address Counter

This block produces the address for a synchronous burst memory. A base address is taken from the address input on a rising clock edge whenever a start strobe is accepted. There are two start strobes. The processor-side strobe is qualified by a chip-select input. The controller-side strobe is accepted unconditionally. After a start, the low two address bits form a burst offset. The offset steps only on cycles where the advance input is high, and it stays inside an aligned group of four words.

The step order is chosen by a static order input. With it high, the offset counts up modulo four from the loaded low bits. With it low, which is the tie-off default, the offset on beat n is the loaded low bits XOR n. Bursts are optional: a new address may be loaded on every cycle and appears on the output after that edge, with no dead cycle.

Top module: `burst_addr_ctr`

## Requirements
- R1: While rst_ni is low, addr_o and ofs_o are zero; reset acts asynchronously.
- R2: When proc_start_i and chip_sel_i are both high at a rising edge, addr_o equals the sampled addr_i after that edge.
- R3: proc_start_i has no effect while chip_sel_i is low; the state then follows the other inputs as if it were low.
- R4: When ctrl_start_i is high at a rising edge, addr_o equals the sampled addr_i after that edge, whatever chip_sel_i is.
- R5: When both strobes are accepted in the same cycle, a single load of addr_i takes place.
- R6: With linear_i high, each advance raises ofs_o by one modulo 4, and the upper address bits do not change.
- R7: With linear_i low, the offset on beat n (n = 0..3 after a load) is the loaded low two bits XOR n.
- R8: With no accepted strobe and adv_i low, addr_o holds its value.
- R9: The fourth advance after a load returns the offset to the loaded low bits in both orders.
- R10: Loads on consecutive cycles each appear on addr_o one edge later.
- R11: An accepted strobe takes priority over adv_i in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Rising-edge clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| addr_i | input | ADDR_W | External address to load |
| proc_start_i | input | 1 | Processor-side start strobe, qualified by chip_sel_i |
| ctrl_start_i | input | 1 | Controller-side start strobe, always accepted |
| chip_sel_i | input | 1 | Chip select that gates proc_start_i |
| adv_i | input | 1 | Advance the burst offset by one beat |
| linear_i | input | 1 | 1 = linear order, 0 = interleaved order |
| addr_o | output | ADDR_W | Current full address |
| ofs_o | output | OFS_W | Current burst offset (low address bits) |

## Verification
The checker tests on every cycle that each accepted strobe of either kind loads the address of the previous edge. It also tests that idle cycles hold the address, that the upper bits stay fixed between loads, and that a linear advance adds one to the offset. The interleaved XOR sequence, the wrap after four beats, the priority of a strobe over an advance, and back-to-back loads depend on the loaded base and on the beat count. They are shown only by the bench's scripted bursts and their expected addresses.

// File: rtl/burst_ctr_pkg.sv
package burst_ctr_pkg;
  typedef enum logic {
    ORDER_INTERLEAVED = 1'b0,
    ORDER_LINEAR      = 1'b1
  } burst_order_e;
endpackage

// File: rtl/burst_start_arb.sv
module burst_start_arb (
  input  logic proc_start_i,
  input  logic ctrl_start_i,
  input  logic chip_sel_i,
  output logic load_o
);
  logic proc_ok;
  // processor strobe counts only when selected; either source loads the same bus
  assign proc_ok = proc_start_i & chip_sel_i;
  assign load_o  = proc_ok | ctrl_start_i;
endmodule

// File: rtl/burst_offset_seq.sv
module burst_offset_seq
  import burst_ctr_pkg::*;
#(
  parameter int unsigned OFS_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic             adv_i,
  input  logic             linear_i,
  input  logic [OFS_W-1:0] base_i,
  output logic [OFS_W-1:0] ofs_o
);
  logic [OFS_W-1:0] base_q;
  logic [OFS_W-1:0] beat_q;
  logic [OFS_W-1:0] lin_ofs;
  logic [OFS_W-1:0] int_ofs;
  burst_order_e     order;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      base_q <= '0;
      beat_q <= '0;
    end else if (load_i) begin
      base_q <= base_i;
      beat_q <= '0;
    end else if (adv_i) begin
      beat_q <= beat_q + 1'b1;
    end
  end

  assign lin_ofs = base_q + beat_q;

  for (genvar b = 0; b < OFS_W; b++) begin : g_intl
    assign int_ofs[b] = base_q[b] ^ beat_q[b];
  end

  assign order = burst_order_e'(linear_i);

  always_comb begin
    unique case (order)
      ORDER_LINEAR:      ofs_o = lin_ofs;
      default:           ofs_o = int_ofs;
    endcase
  end
endmodule

// File: rtl/burst_addr_ctr.sv
module burst_addr_ctr #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              proc_start_i,
  input  logic              ctrl_start_i,
  input  logic              chip_sel_i,
  input  logic              adv_i,
  input  logic              linear_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [OFS_W-1:0]  ofs_o
);
  localparam int unsigned HI_W = ADDR_W - OFS_W;

  logic            load_s;
  logic [HI_W-1:0] hi_q;
  logic [OFS_W-1:0] ofs_s;

  burst_start_arb u_arb (
    .proc_start_i(proc_start_i),
    .ctrl_start_i(ctrl_start_i),
    .chip_sel_i  (chip_sel_i),
    .load_o      (load_s)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     hi_q <= '0;
    else if (load_s) hi_q <= addr_i[ADDR_W-1:OFS_W];
  end

  burst_offset_seq #(.OFS_W(OFS_W)) u_seq (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .load_i  (load_s),
    .adv_i   (adv_i),
    .linear_i(linear_i),
    .base_i  (addr_i[OFS_W-1:0]),
    .ofs_o   (ofs_s)
  );

  assign addr_o = {hi_q, ofs_s};
  assign ofs_o  = ofs_s;
endmodule

// File: rtl/burst_addr_ctr_chk.sv
module burst_addr_ctr_chk #(
  parameter int unsigned ADDR_W = 16,
  parameter int unsigned OFS_W  = 2
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [ADDR_W-1:0] addr_i,
  input logic              proc_start_i,
  input logic              ctrl_start_i,
  input logic              chip_sel_i,
  input logic              adv_i,
  input logic              linear_i,
  input logic [ADDR_W-1:0] addr_o,
  input logic [OFS_W-1:0]  ofs_o
);
  logic acc;
  assign acc = (proc_start_i & chip_sel_i) | ctrl_start_i;

  AST_PROC_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (proc_start_i && chip_sel_i) |=> addr_o == $past(addr_i)); // R2
  AST_CTRL_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_start_i |=> addr_o == $past(addr_i)); // R4
  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && !adv_i) |=> (addr_o == $past(addr_o) || linear_i != $past(linear_i))); // R8
  AST_UPPER_KEEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !acc |=> addr_o[ADDR_W-1:OFS_W] == $past(addr_o[ADDR_W-1:OFS_W])); // R6
  AST_LIN_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!acc && adv_i && linear_i) |=> (!linear_i || ofs_o == OFS_W'($past(ofs_o) + 1'b1))); // R6
endmodule

bind burst_addr_ctr burst_addr_ctr_chk #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .addr_i(addr_i), .proc_start_i(proc_start_i),
  .ctrl_start_i(ctrl_start_i), .chip_sel_i(chip_sel_i), .adv_i(adv_i),
  .linear_i(linear_i), .addr_o(addr_o), .ofs_o(ofs_o)
);

// File: tb/sim_burst_addr_ctr.sv
module sim_burst_addr_ctr;
  localparam int ADDR_W = 16;
  localparam int OFS_W  = 2;
  localparam int NV     = 18;

  typedef struct packed {
    logic        proc;
    logic        ctrl;
    logic        cs;
    logic        adv;
    logic        lin;
    logic [15:0] addr;
    logic [15:0] exp;
    logic [3:0]  req;
  } vec_t;

  // proc ctrl cs adv lin addr exp req
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h1235,16'h1235,4'd4},  // R4
    '{1'b0,1'b0,1'b0,1'b1,1'b1,16'h0000,16'h1236,4'd6},  // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b1,16'hFFFF,16'h1237,4'd6},  // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b1,16'h0000,16'h1234,4'd6},  // R6 wrap of offset
    '{1'b0,1'b0,1'b0,1'b1,1'b1,16'h0000,16'h1235,4'd9},  // R9
    '{1'b0,1'b0,1'b1,1'b0,1'b1,16'h9999,16'h1235,4'd8},  // R8
    '{1'b1,1'b0,1'b0,1'b0,1'b1,16'h4440,16'h1235,4'd3},  // R3
    '{1'b1,1'b0,1'b1,1'b0,1'b0,16'hABC2,16'hABC2,4'd2},  // R2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC3,4'd7},  // R7 2^1
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC0,4'd7},  // R7 2^2
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC1,4'd7},  // R7 2^3
    '{1'b0,1'b0,1'b0,1'b1,1'b0,16'h0000,16'hABC2,4'd9},  // R9
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0101,16'h0101,4'd4},  // R4 without select
    '{1'b0,1'b1,1'b0,1'b1,1'b1,16'h7773,16'h7773,4'd11}, // R11
    '{1'b1,1'b0,1'b1,1'b0,1'b1,16'h0010,16'h0010,4'd10}, // R10
    '{1'b0,1'b1,1'b0,1'b0,1'b1,16'h0020,16'h0020,4'd10}, // R10
    '{1'b1,1'b1,1'b1,1'b0,1'b1,16'h5551,16'h5551,4'd5},  // R5
    '{1'b1,1'b0,1'b0,1'b1,1'b1,16'hEEE0,16'h5552,4'd3}   // R3 with advance
  };

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic              proc_s = 1'b0, ctrl_s = 1'b0, cs = 1'b0, adv = 1'b0, lin = 1'b0;
  logic [ADDR_W-1:0] addr_q;
  logic [OFS_W-1:0]  ofs_q;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  burst_addr_ctr #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) u0 (
    .clk_i(clk), .rst_ni(rst_n), .addr_i(addr), .proc_start_i(proc_s),
    .ctrl_start_i(ctrl_s), .chip_sel_i(cs), .adv_i(adv), .linear_i(lin),
    .addr_o(addr_q), .ofs_o(ofs_q)
  );

  task automatic check(input int req, input logic [ADDR_W-1:0] act, input logic [ADDR_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL R%0d actual=%h expected=%h", req, act, exp);
    end
  endtask

  initial begin
    #5;
    check(1, addr_q, '0);                         // R1 during reset
    check(1, {14'd0, ofs_q}, '0);                 // R1
    @(negedge clk); @(negedge clk);
    rst_n = 1'b1;
    for (int i = 0; i < NV; i++) begin
      proc_s = VEC[i].proc; ctrl_s = VEC[i].ctrl; cs = VEC[i].cs;
      adv = VEC[i].adv; lin = VEC[i].lin; addr = VEC[i].addr;
      @(negedge clk);
      check(int'(VEC[i].req), addr_q, VEC[i].exp);
      check(int'(VEC[i].req), {14'd0, ofs_q}, {14'd0, VEC[i].exp[1:0]});
    end
    // R1: asynchronous reset mid-run
    proc_s = 1'b0; ctrl_s = 1'b0; adv = 1'b0;
    #3 rst_n = 1'b0;
    #2 check(1, addr_q, '0);
    @(negedge clk);
    rst_n = 1'b1;
    // R7 starting from an odd base: 3,2,1,0
    ctrl_s = 1'b1; lin = 1'b0; addr = 16'h00F3;
    @(negedge clk);
    check(7, addr_q, 16'h00F3);
    ctrl_s = 1'b0; adv = 1'b1;
    @(negedge clk);
    check(7, addr_q, 16'h00F2);
    @(negedge clk);
    check(7, addr_q, 16'h00F1);
    @(negedge clk);
    check(7, addr_q, 16'h00F0);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end
endmodule